// File: doc/BRIEF.md
# Block-RAM Integer Register File with Write-Back Bypass

This block is the integer register file of a small pipelined RISC-V core: 32 registers of 32 bits. It holds them in synchronous dual-ported RAM instead of a wall of flip-flops followed by 32-to-1 multiplexers. Each source operand has its own RAM copy. On each copy one port only reads and the other only writes, and every write-back goes into both copies, so they always hold the same contents.

The RAM read output is registered. That register is also the decode-to-execute pipeline register: an operand appears one clock after its address is presented with the read enable high. The RAM does not pass a same-address write through to its read port. A bypass register outside the RAM therefore captures the write-back data when a read meets a write to the same register, and selects it in place of the RAM output.

While the read enable is low, the decode stage is stalled. Each operand output holds its value, but it still follows a write-back to the register it is holding. Register x0 always reads as zero, and writes to it are dropped.

Top module: `rf_bram_forward`

## Requirements
- R1: A value written to register k (k from 1 to 31) is returned on either operand by any later read of k, until k is written again.
- R2: An operand output changes only on the clock edge at which the read enable is high. From that edge on it shows the register named by the read address sampled at that edge.
- R3: Reading register 0 gives zero on the operand. A write with address 0 changes no register.
- R4: If the write enable is high and the write address equals a read address at the edge where that read is issued, the operand shows the new write data after that edge, not the old contents.
- R5: A write at one edge followed by a read of the same register at the next edge returns the newly written value.
- R6: While the read enable is low, both operand outputs keep their values. Writes to other registers do not disturb them.
- R7: While the read enable is low, a write to the register an operand is holding (not register 0) updates that operand to the write data after that edge.
- R8: The two operands are read independently from separate copies. Every write reaches both copies.
- R9: While reset is asserted, and after it is released, both operands read zero until the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the read-side state |
| rd_en | input | 1 | Read issue; low stalls both operand outputs |
| rs_a_addr | input | 5 | Register number for operand A |
| rs_b_addr | input | 5 | Register number for operand B |
| wb_en | input | 1 | Write-back enable |
| wb_addr | input | 5 | Write-back register number |
| wb_data | input | 32 | Write-back value |
| opnd_a | output | 32 | Operand A, registered |
| opnd_b | output | 32 | Operand B, registered |

## Verification
After reset and a full fill of all registers, the file is driven with directed patterns. These are: a same-edge write and read of one register, which shows whether the bypass is used rather than the stale RAM word; a write followed by a read at the next edge, which shows whether the RAM write landed; x0 writes and reads, which show suppression and the forced zero; and stalls with writes to the held and to other registers, which separate holding from updating. A long random phase then uses addresses limited to a few registers, so that collisions, stalls and x0 cases happen often. Each cycle it compares both operands with a behavioural array model, and the two read addresses are drawn apart so that a crossed or missing copy shows.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
    localparam int unsigned XLEN_DEF  = 32;
    localparam int unsigned NREGS_DEF = 32;
    localparam int unsigned NRD_DEF   = 2;

    // True when a qualified write targets the given register number.
    function automatic logic wr_hits(input logic en, input logic [7:0] wa, input logic [7:0] ra);
        return en && (wa == ra);
    endfunction
endpackage

// File: rtl/rf_ram.sv
// Simple dual-port synchronous RAM: one write-only port, one read-only port,
// registered read data, no write-to-read pass-through.
module rf_ram #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = re ? mem[raddr] : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rf_read_port.sv
// Bypass and zero selection around one RAM copy's registered output.
module rf_read_port
    import rfb_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [AW-1:0]    raddr,
    input  logic             wr_en,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] ram_rdata,
    output logic [WIDTH-1:0] operand
);
    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] byp;
        logic             sel;
        logic             zero;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     hit_new, hit_held;

    always_comb begin
        st_d     = st_q;
        hit_new  = wr_hits(wr_en, 8'(waddr), 8'(raddr));
        hit_held = wr_hits(wr_en, 8'(waddr), 8'(st_q.addr)) && !st_q.zero;
        if (rd_en) begin
            st_d.addr = raddr;
            st_d.zero = (raddr == '0);
            st_d.sel  = hit_new;
            if (hit_new) st_d.byp = wdata;
        end else if (hit_held) begin
            st_d.sel = 1'b1;
            st_d.byp = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr <= '0;
            st_q.byp  <= '0;
            st_q.sel  <= 1'b0;
            st_q.zero <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.zero)     operand = '0;
        else if (st_q.sel) operand = st_q.byp;
        else               operand = ram_rdata;
    end

    // R3: a read of register 0 yields zero on the next cycle
    a_r3_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && raddr == '0) |=> (operand == '0));

    // R4: same-edge write and read of one register forwards the new data
    a_r4_same_edge_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && waddr == raddr) |=> (operand == $past(wdata)));

    // R6: a stall without a write to the held register keeps the operand
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !(wr_en && waddr == st_q.addr)) |=> $stable(operand));

    // R7: a write to the held register during a stall reaches the operand
    a_r7_stall_update: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && wr_en && waddr == st_q.addr && !st_q.zero) |=> (operand == $past(wdata)));
endmodule

// File: rtl/rf_bram_forward.sv
module rf_bram_forward
    import rfb_pkg::*;
#(
    parameter int unsigned XLEN  = XLEN_DEF,
    parameter int unsigned NREGS = NREGS_DEF,
    localparam int unsigned AW   = $clog2(NREGS),
    localparam int unsigned NRD  = NRD_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [AW-1:0]   rs_a_addr,
    input  logic [AW-1:0]   rs_b_addr,
    input  logic            wb_en,
    input  logic [AW-1:0]   wb_addr,
    input  logic [XLEN-1:0] wb_data,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b
);
    logic            wr_q;      // write-back qualified: register 0 never stored
    logic [AW-1:0]   rd_addr [NRD];
    logic [XLEN-1:0] ram_q   [NRD];
    logic [XLEN-1:0] opnd    [NRD];

    assign wr_q       = wb_en && (wb_addr != '0);
    assign rd_addr[0] = rs_a_addr;
    assign rd_addr[1] = rs_b_addr;

    for (genvar g = 0; g < NRD; g++) begin : g_copy
        rf_ram #(.WIDTH(XLEN), .DEPTH(NREGS)) u_ram (
            .clk   (clk),
            .we    (wr_q),
            .waddr (wb_addr),
            .wdata (wb_data),
            .re    (rd_en),
            .raddr (rd_addr[g]),
            .rdata (ram_q[g])
        );
        rf_read_port #(.WIDTH(XLEN), .AW(AW)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_en     (rd_en),
            .raddr     (rd_addr[g]),
            .wr_en     (wr_q),
            .waddr     (wb_addr),
            .wdata     (wb_data),
            .ram_rdata (ram_q[g]),
            .operand   (opnd[g])
        );
    end

    assign opnd_a = opnd[0];
    assign opnd_b = opnd[1];

    // R9: operands read zero during reset
    always_comb begin
        if (!rst_n) a_r9_reset_zero: assert (opnd_a == '0 && opnd_b == '0);
    end

    // R2: with reads stalled and no write-back, neither operand moves
    a_r2_no_move_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wb_en) |=> ($stable(opnd_a) && $stable(opnd_b)));
endmodule

// File: tb/tb_rf_bram_forward.sv
module tb_rf_bram_forward;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rs_a_addr = '0, rs_b_addr = '0, wb_addr = '0;
    logic        wb_en = 1'b0;
    logic [31:0] wb_data = '0;
    logic [31:0] opnd_a, opnd_b;

    int tests = 0, fails = 0;
    bit done = 0;

    // behavioural reference
    logic [31:0] regs [32];
    logic [4:0]  held_a = '0, held_b = '0;
    logic [31:0] exp_a = '0, exp_b = '0;

    always #5 clk = ~clk;

    rf_bram_forward dut (.*);

    task automatic check(input string tag);
        tests++;
        if (opnd_a !== exp_a) begin
            fails++;
            $display("FAIL %s opnd_a actual=%h expected=%h", tag, opnd_a, exp_a);
        end
        tests++;
        if (opnd_b !== exp_b) begin
            fails++;
            $display("FAIL %s opnd_b actual=%h expected=%h", tag, opnd_b, exp_b);
        end
    endtask

    // Apply one cycle of stimulus (called just after a falling edge),
    // update the reference at the rising edge, compare at the next falling edge.
    task automatic step(input bit re, input logic [4:0] aa, input logic [4:0] ab,
                        input bit we, input logic [4:0] wa, input logic [31:0] wd,
                        input string tag);
        rd_en = re; rs_a_addr = aa; rs_b_addr = ab;
        wb_en = we; wb_addr = wa; wb_data = wd;
        @(posedge clk);
        if (re) begin
            held_a = aa; held_b = ab;
            exp_a = (aa == 0) ? 32'h0 : ((we && wa == aa) ? wd : regs[aa]);
            exp_b = (ab == 0) ? 32'h0 : ((we && wa == ab) ? wd : regs[ab]);
        end else begin
            if (we && wa != 0 && wa == held_a) exp_a = wd;
            if (we && wa != 0 && wa == held_b) exp_b = wd;
        end
        if (we && wa != 0) regs[wa] = wd;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 32'h0;
        repeat (3) @(negedge clk);
        check("R9 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset");

        // fill every register while stalled; operands stay zero
        for (int i = 1; i < 32; i++)
            step(0, 5'd0, 5'd0, 1, 5'(i), 32'hA500_0000 + 32'(i * 257), "R6 fill stalled");

        // R1 / R8: read back each register on both operands, different addresses
        for (int i = 1; i < 32; i++)
            step(1, 5'(i), 5'(32 - i), 0, 5'd0, 32'h0, "R1 R8 readback");

        // R3: write to x0 ignored, read of x0 zero
        step(1, 5'd0, 5'd0, 1, 5'd0, 32'hDEAD_BEEF, "R3 x0 write and read");
        step(1, 5'd0, 5'd3, 0, 5'd0, 32'h0, "R3 x0 read after write");

        // R4: same-edge collision
        step(1, 5'd7, 5'd7, 1, 5'd7, 32'h1111_2222, "R4 same edge bypass");
        step(1, 5'd8, 5'd7, 1, 5'd8, 32'h3333_4444, "R4 bypass on A only");

        // R5: write then read next edge
        step(0, 5'd0, 5'd0, 1, 5'd9, 32'h5555_6666, "R6 stalled write other");
        step(1, 5'd9, 5'd9, 0, 5'd0, 32'h0, "R5 write then read");

        // R2: address change without read enable has no effect
        step(0, 5'd12, 5'd13, 0, 5'd0, 32'h0, "R2 addr change stalled");
        step(1, 5'd12, 5'd13, 0, 5'd0, 32'h0, "R2 read issued");

        // R6 / R7: stall holding registers 12 and 13
        step(0, 5'd1, 5'd2, 1, 5'd20, 32'h7777_0000, "R6 write to other reg");
        step(0, 5'd1, 5'd2, 1, 5'd12, 32'h7777_1212, "R7 write to held A");
        step(0, 5'd1, 5'd2, 1, 5'd13, 32'h7777_1313, "R7 write to held B");
        step(0, 5'd1, 5'd2, 0, 5'd0, 32'h0, "R6 hold after update");
        step(1, 5'd20, 5'd12, 0, 5'd0, 32'h0, "R1 read after stall writes");
        step(1, 5'd0, 5'd5, 0, 5'd0, 32'h0, "R3 x0 on A");
        step(0, 5'd0, 5'd0, 1, 5'd0, 32'hFFFF_FFFF, "R3 R7 x0 held no update");

        // random phase with a small address range
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] ra, rb, wa;
            ra = 5'($urandom_range(0, 5));
            rb = 5'($urandom_range(0, 5));
            wa = 5'($urandom_range(0, 5));
            step(($urandom_range(0, 3) != 0), ra, rb, ($urandom_range(0, 1) == 1), wa,
                 $urandom, "R1 R4 R5 R6 R7 R8 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule